// File: doc/BRIEF.md
# Serial-Access Descriptor Ring

This block is a small per-channel queue of descriptors. It holds four entries, and each entry is four 32-bit words. A producer loads an entry by presenting its words one after another on a single write port. A consumer drains the oldest entry the same way, one word per read strobe. An entry becomes visible to the consumer only after all four of its words have been written. The read slot is released only after all four of its words have been read.

A single 32-bit status word reports the ring's state:

| Bits | Contents |
|---|---|
| 1:0 | write slot pointer |
| 5:4 | read slot pointer |
| 8 | empty flag |
| 9 | full flag |
| 10 | sticky error flag |
| 13:12 | write word counter |
| 15:14 | read word counter |
| 31:16 | saturating count of rejected accesses |

Software clears the error flag by writing the status word with bit 10 set. Two control levels, a ring reset and a counter clear, restore the pointers and zero the count. Each can be used on its own.

Top module: `descRing`

## Requirements
- R1: After rstN is released, statusWord reads 0x0000_0100: empty, with all pointers, counters and flags at zero.
- R2: Each accepted write word advances the write word counter (bits 13:12) through 0,1,2,3. The write slot pointer (bits 1:0) advances, with wrap from 3 to 0, only when the fourth word of an entry is accepted. The empty flag stays set while an entry is only partly written.
- R3: rdData shows word k of the oldest complete entry, where k is the read word counter (bits 15:14). Each rdStrobe on a non-empty ring advances that counter. The read slot pointer (bits 5:4) advances only on the fourth word.
- R4: When the two slot pointers are equal, exactly one of empty (bit 8) and full (bit 9) is set. When the pointers differ, neither is set.
- R5: A write word presented while full is dropped, and the stored entries stay intact. The rejected-access count increments and the error flag (bit 10) is set.
- R6: A read strobe while empty presents rdData = 0, increments the rejected-access count, and leaves both pointers unchanged. It does not set the error flag.
- R7: The rejected-access count (bits 31:16) saturates at 0xFFFF.
- R8: A status write with bit 10 set clears the error flag. A status write with bit 10 clear has no effect. If an overflow occurs in the same cycle, the flag stays set.
- R9: While ringReset is high, writes and reads are ignored. Pointers and word counters go to zero, empty is set and the error flag is cleared. The count is kept.
- R10: counterClear zeroes the count and leaves pointers, word counters and flags untouched.
- R11: Entries leave in the order they were completed, across pointer wrap, with each word in its written position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rstN | input | 1 | asynchronous active-low reset |
| wrValid | input | 1 | present one write word this cycle |
| wrData | input | 32 | write word |
| rdStrobe | input | 1 | consume the word shown on rdData |
| rdData | output | 32 | current read word, zero when empty |
| statusWrEn | input | 1 | status write strobe |
| statusWrData | input | 32 | status write data, only bit 10 is used |
| ringReset | input | 1 | ring reset level |
| counterClear | input | 1 | count clear level |
| statusWord | output | 32 | packed status |

## Verification
The assertions assume that every input is synchronous to clk and is stable around the rising edge. They also assume that rstN is applied once at the start. Beyond that, no input combination is excluded: overflow with a clear, and reset with active traffic, are all legal. The stimulus changes inputs only on falling edges. It deliberately drives the overlapping cases (a write while full together with an error clear, and writes and reads held during a ring reset) so that the priority rules are exercised.

// File: rtl/descRingPkg.sv
package descRingPkg;
  localparam int WORD_W    = 32;
  localparam int SLOT_CNT  = 4;
  localparam int PIECE_CNT = 4;
  localparam int CNT_W     = 16;
  localparam int SLOT_W    = $clog2(SLOT_CNT);
  localparam int PIECE_W   = $clog2(PIECE_CNT);

  // status word layout (fixed, software decodes it)
  localparam int WR_PTR_LSB  = 0;
  localparam int RD_PTR_LSB  = 4;
  localparam int EMPTY_BIT   = 8;
  localparam int FULL_BIT    = 9;
  localparam int ERR_BIT     = 10;
  localparam int WR_PROG_LSB = 12;
  localparam int RD_PROG_LSB = 14;
  localparam int CNT_LSB     = 16;

  typedef struct packed {
    logic               storeEn;
    logic [SLOT_W-1:0]  storeSlot;
    logic [PIECE_W-1:0] storePiece;
    logic [SLOT_W-1:0]  loadSlot;
    logic [PIECE_W-1:0] loadPiece;
    logic               loadZero;
  } ringStrobe_t;
endpackage

// File: rtl/descRingCtrl.sv
module descRingCtrl
  import descRingPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic               rdStrobe,
  input  logic               errClrReq,
  input  logic               ringReset,
  input  logic               counterClear,
  output ringStrobe_t        strobe,
  output logic [SLOT_W-1:0]  wrPtr,
  output logic [SLOT_W-1:0]  rdPtr,
  output logic [PIECE_W-1:0] wrPiece,
  output logic [PIECE_W-1:0] rdPiece,
  output logic               emptyFlag,
  output logic               fullFlag,
  output logic               errFlag,
  output logic [CNT_W-1:0]   evtCount
);
  localparam logic [CNT_W-1:0]   CNT_MAX    = {CNT_W{1'b1}};
  localparam logic [PIECE_W-1:0] PIECE_LAST = PIECE_W'(PIECE_CNT - 1);
  localparam logic [SLOT_W-1:0]  SLOT_LAST  = SLOT_W'(SLOT_CNT - 1);

  logic acceptWr, acceptRd, overflowEvt, underflowEvt, wrLast, rdLast;
  logic [SLOT_W-1:0] wrPtrNext, rdPtrNext;

  function automatic logic [SLOT_W-1:0] slotInc(input logic [SLOT_W-1:0] s);
    return (s == SLOT_LAST) ? '0 : s + SLOT_W'(1);
  endfunction

  function automatic logic [PIECE_W-1:0] pieceInc(input logic [PIECE_W-1:0] p);
    return (p == PIECE_LAST) ? '0 : p + PIECE_W'(1);
  endfunction

  assign emptyFlag    = (wrPtr == rdPtr) && !fullFlag;
  assign acceptWr     = wrValid && !fullFlag && !ringReset;
  assign overflowEvt  = wrValid && fullFlag && !ringReset;
  assign acceptRd     = rdStrobe && !emptyFlag && !ringReset;
  assign underflowEvt = rdStrobe && emptyFlag && !ringReset;
  assign wrLast       = acceptWr && (wrPiece == PIECE_LAST);
  assign rdLast       = acceptRd && (rdPiece == PIECE_LAST);
  assign wrPtrNext    = slotInc(wrPtr);
  assign rdPtrNext    = slotInc(rdPtr);

  always_comb begin
    strobe            = '0;
    strobe.storeEn    = acceptWr;
    strobe.storeSlot  = wrPtr;
    strobe.storePiece = wrPiece;
    strobe.loadSlot   = rdPtr;
    strobe.loadPiece  = rdPiece;
    strobe.loadZero   = emptyFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      wrPiece  <= '0;
      rdPiece  <= '0;
      fullFlag <= 1'b0;
    end else if (ringReset) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      wrPiece  <= '0;
      rdPiece  <= '0;
      fullFlag <= 1'b0;
    end else begin
      if (acceptWr) wrPiece <= pieceInc(wrPiece);
      if (acceptRd) rdPiece <= pieceInc(rdPiece);
      if (wrLast)   wrPtr   <= wrPtrNext;
      if (rdLast)   rdPtr   <= rdPtrNext;
      if (wrLast && !rdLast && (wrPtrNext == rdPtr)) fullFlag <= 1'b1;
      else if (rdLast && !wrLast)                    fullFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                evtCount <= '0;
    else if (counterClear)                    evtCount <= '0;
    else if ((overflowEvt || underflowEvt) && (evtCount != CNT_MAX))
                                              evtCount <= evtCount + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (ringReset)   errFlag <= 1'b0;
    else if (overflowEvt) errFlag <= 1'b1;
    else if (errClrReq)   errFlag <= 1'b0;
  end
endmodule

// File: rtl/descRingData.sv
module descRingData
  import descRingPkg::*;
(
  input  logic              clk,
  input  ringStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] slotWords [SLOT_CNT][PIECE_CNT];

  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.storeEn && (strobe.storeSlot == SLOT_W'(s)))
        slotWords[s][strobe.storePiece] <= wrData;
    end
  end

  always_comb begin
    if (strobe.loadZero) rdData = '0;
    else                 rdData = slotWords[strobe.loadSlot][strobe.loadPiece];
  end
endmodule

// File: rtl/descRing.sv
module descRing
  import descRingPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [31:0] wrData,
  input  logic        rdStrobe,
  output logic [31:0] rdData,
  input  logic        statusWrEn,
  input  logic [31:0] statusWrData,
  input  logic        ringReset,
  input  logic        counterClear,
  output logic [31:0] statusWord
);
  ringStrobe_t        strobe;
  logic [SLOT_W-1:0]  wrPtr, rdPtr;
  logic [PIECE_W-1:0] wrPiece, rdPiece;
  logic               emptyFlag, fullFlag, errFlag;
  logic [CNT_W-1:0]   evtCount;
  logic               errClrReq;

  assign errClrReq = statusWrEn && statusWrData[ERR_BIT];

  descRingCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
    .errClrReq(errClrReq), .ringReset(ringReset), .counterClear(counterClear),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr), .wrPiece(wrPiece),
    .rdPiece(rdPiece), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .errFlag(errFlag), .evtCount(evtCount)
  );

  descRingData u_data (
    .clk(clk), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );

  always_comb begin
    statusWord = '0;
    statusWord[WR_PTR_LSB +: SLOT_W]   = wrPtr;
    statusWord[RD_PTR_LSB +: SLOT_W]   = rdPtr;
    statusWord[EMPTY_BIT]              = emptyFlag;
    statusWord[FULL_BIT]               = fullFlag;
    statusWord[ERR_BIT]                = errFlag;
    statusWord[WR_PROG_LSB +: PIECE_W] = wrPiece;
    statusWord[RD_PROG_LSB +: PIECE_W] = rdPiece;
    statusWord[CNT_LSB +: CNT_W]       = evtCount;
  end
endmodule

// File: rtl/descRingChk.sv
module descRingChk (
  input logic        clk,
  input logic        rstN,
  input logic        wrValid,
  input logic        rdStrobe,
  input logic [31:0] rdData,
  input logic        ringReset,
  input logic        counterClear,
  input logic [31:0] statusWord
);
  // R4
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusWord[8] && statusWord[9]));

  // R4
  ptr_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[1:0] != statusWord[5:4]) |-> (!statusWord[8] && !statusWord[9]));

  // R5
  overflow_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[9] && wrValid && !ringReset) |=> statusWord[10]);

  // R6
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[8] && rdStrobe) |-> (rdData == 32'h0));

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    counterClear |=> (statusWord[31:16] == 16'h0));

  // R9
  ring_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ringReset |=> (statusWord[15:0] == 16'h0100));

  // R2
  wrptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !ringReset) |=> $stable(statusWord[1:0]));
endmodule

bind descRing descRingChk u_descRingChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
  .rdData(rdData), .ringReset(ringReset), .counterClear(counterClear),
  .statusWord(statusWord)
);

// File: tb/test_descRing.sv
module test_descRing;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdStrobe = 1'b0;
  logic [31:0] rdData;
  logic        statusWrEn = 1'b0;
  logic [31:0] statusWrData = '0;
  logic        ringReset = 1'b0;
  logic        counterClear = 1'b0;
  logic [31:0] statusWord;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  descRing i_descRing (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdData(rdData), .statusWrEn(statusWrEn),
    .statusWrData(statusWrData), .ringReset(ringReset),
    .counterClear(counterClear), .statusWord(statusWord)
  );

  function automatic logic [31:0] es(int wp, int rp, int wpc, int rpc,
                                     bit emp, bit ful, bit err, int cnt);
    logic [31:0] v = '0;
    v[1:0] = 2'(wp);   v[5:4] = 2'(rp);
    v[8] = emp; v[9] = ful; v[10] = err;
    v[13:12] = 2'(wpc); v[15:14] = 2'(rpc);
    v[31:16] = 16'(cnt);
    return v;
  endfunction

  function automatic logic [31:0] wordOf(int e, int p);
    return 32'hC0DE_0000 | 32'(e << 4) | 32'(p);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic pushWord(logic [31:0] d);
    wrValid = 1'b1; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic popWord(output logic [31:0] d);
    d = rdData;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic pushEntry(int e);
    for (int p = 0; p < 4; p++) pushWord(wordOf(e, p));
  endtask

  task automatic popEntryCheck(int e, string req);
    logic [31:0] d;
    for (int p = 0; p < 4; p++) begin
      popWord(d);
      check(req, d, wordOf(e, p));
    end
  endtask

  task automatic testReset();
    check("R1 reset status", statusWord, 32'h0000_0100);
  endtask

  task automatic testWriteProgress();
    for (int p = 0; p < 3; p++) begin
      pushWord(wordOf(0, p));
      check("R2 partial write", statusWord, es(0, 0, p + 1, 0, 1, 0, 0, 0));
    end
    pushWord(wordOf(0, 3));
    check("R2 entry complete", statusWord, es(1, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic testReadProgress();
    logic [31:0] d;
    for (int p = 0; p < 3; p++) begin
      popWord(d);
      check("R3 read word", d, wordOf(0, p));
      check("R3 read progress", statusWord, es(1, 0, 0, p + 1, 0, 0, 0, 0));
    end
    popWord(d);
    check("R3 last word", d, wordOf(0, 3));
    check("R3 slot released", statusWord, es(1, 1, 0, 0, 1, 0, 0, 0));
  endtask

  task automatic testOverflowAndOrder();
    for (int e = 1; e <= 4; e++) pushEntry(e);
    check("R4 full at equal pointers", statusWord, es(1, 1, 0, 0, 0, 1, 0, 0));
    pushWord(32'hDEAD_BEEF);
    check("R5 overflow", statusWord, es(1, 1, 0, 0, 0, 1, 1, 1));
    for (int e = 1; e <= 4; e++) popEntryCheck(e, "R11 order across wrap, R5 intact");
    check("R4 empty after drain", statusWord, es(1, 1, 0, 0, 1, 0, 1, 1));
  endtask

  task automatic testUnderflow();
    logic [31:0] d;
    popWord(d);
    check("R6 underflow data", d, 32'h0);
    check("R6 underflow status", statusWord, es(1, 1, 0, 0, 1, 0, 1, 2));
  endtask

  task automatic testErrClear();
    statusWrEn = 1'b1; statusWrData = 32'hFFFF_FBFF;
    @(negedge clk);
    statusWrEn = 1'b0;
    check("R8 write without bit10", statusWord, es(1, 1, 0, 0, 1, 0, 1, 2));
    statusWrEn = 1'b1; statusWrData = 32'h0000_0400;
    @(negedge clk);
    statusWrEn = 1'b0;
    check("R8 clear error", statusWord, es(1, 1, 0, 0, 1, 0, 0, 2));
  endtask

  task automatic testCounterClear();
    pushWord(wordOf(5, 0));
    pushWord(wordOf(5, 1));
    check("R2 partial stays empty", statusWord, es(1, 1, 2, 0, 1, 0, 0, 2));
    counterClear = 1'b1;
    @(negedge clk);
    counterClear = 1'b0;
    check("R10 counter clear", statusWord, es(1, 1, 2, 0, 1, 0, 0, 0));
  endtask

  task automatic testRingReset();
    logic [31:0] d;
    popWord(d);
    check("R6 underflow with partial entry", d, 32'h0);
    check("R6 count", statusWord, es(1, 1, 2, 0, 1, 0, 0, 1));
    ringReset = 1'b1; wrValid = 1'b1; wrData = 32'h1234_5678; rdStrobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ringReset = 1'b0; wrValid = 1'b0; rdStrobe = 1'b0;
    check("R9 ring reset keeps count", statusWord, es(0, 0, 0, 0, 1, 0, 0, 1));
    pushEntry(6);
    check("R9 fresh entry", statusWord, es(1, 0, 0, 0, 0, 0, 0, 1));
    popEntryCheck(6, "R9 partial entry discarded");
    check("R9 after pop", statusWord, es(1, 1, 0, 0, 1, 0, 0, 1));
  endtask

  task automatic testSetWins();
    for (int e = 7; e <= 10; e++) pushEntry(e);
    wrValid = 1'b1; wrData = 32'hBAD0_0000;
    statusWrEn = 1'b1; statusWrData = 32'h0000_0400;
    @(negedge clk);
    wrValid = 1'b0; statusWrEn = 1'b0;
    check("R8 overflow beats clear", statusWord, es(1, 1, 0, 0, 0, 1, 1, 2));
    ringReset = 1'b1; counterClear = 1'b1;
    @(negedge clk);
    ringReset = 1'b0; counterClear = 1'b0;
    check("R9 R10 combined", statusWord, es(0, 0, 0, 0, 1, 0, 0, 0));
  endtask

  task automatic testSaturation();
    rdStrobe = 1'b1;
    repeat (65540) @(negedge clk);
    rdStrobe = 1'b0;
    check("R7 saturation", statusWord, 32'hFFFF_0100);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteProgress();
    testReadProgress();
    testOverflowAndOrder();
    testUnderflow();
    testErrClear();
    testCounterClear();
    testRingReset();
    testSetWins();
    testSaturation();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule